// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical byte address for a processor core that works with four segment base registers: code, data, stack and extra. A segment base is scaled by sixteen (shifted left four places with zero fill) and added to the offset. The block picks the segment from the kind of access and, for general memory operands, from the base register in use. A one-shot override from an instruction prefix can redirect the next general memory operand to any segment. Accesses to the I/O space bypass segmentation and yield a flat address.

Each accepted request drives one registered bus address with byte-lane enables for a 16-bit data path. A word at an odd byte address cannot go out in one transfer, so the block issues it as two byte cycles: the low byte at the odd address, then the high byte at the next offset. The offset wraps inside the segment for that second byte. During such a split the request side is held off for one cycle. The segment registers are loaded through a simple write port.

Top module: `segaddr_gen`

## Requirements
- R1: A segmented access drives bus_addr = ((segment base << 4) + offset) taken to 20 bits. A request accepted on a clock edge shows its first bus cycle on the outputs from that same edge.
- R2: Request kind 0 (instruction fetch) always uses the code segment. A pending or same-cycle override has no effect on it and stays pending.
- R3: Request kind 1 (general memory operand) with no override uses the stack segment when req_base is 2 (BP-style base) or 3 (stack-pointer base). It uses the data segment when req_base is 0 (no base or index only) or 1 (BX-style base).
- R4: Request kind 2 (push/pop) always uses the stack segment and ignores any override.
- R5: Request kind 3 (string destination) always uses the extra segment. An override has no effect on it and stays pending.
- R6: A pulse on pfx_valid with code pfx_seg makes the next kind-1 request use that segment, and that request consumes it. A prefix given in the same cycle as a kind-1 request applies to that request. Segment codes are 0 code, 1 data, 2 stack, 3 extra.
- R7: Request kind 4 (I/O) drives the 16-bit offset as the address with bus_addr[19:16] = 0, sets bus_io and adds no segment.
- R8: Byte enables: a byte at an even address gives bus_be = 01 and at an odd address 10. A word at an even address gives 11 in a single cycle with bus_split = 0.
- R9: A word at an odd address takes two cycles. In the first, bus_split = 1, bus_phase = 0, bus_be = 10 at the odd address. In the next, bus_phase = 1, bus_be = 01 at the address formed from (offset + 1) mod 2^16. req_ready is 0 during the first of the two cycles.
- R10: Segment base plus offset wraps modulo 2^20.
- R11: seg_wr_en loads seg_wr_data into the segment chosen by seg_wr_sel (same codes as R6). A request in the same cycle as a write uses the old value.
- R12: After reset bus_valid = 0, req_ready = 1, all segment bases are 0 and no override is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Segment base write strobe |
| seg_wr_sel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | New segment base |
| pfx_valid | input | 1 | Override prefix pulse |
| pfx_seg | input | 2 | Override segment code |
| req_valid | input | 1 | Address request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 3 | 0 fetch, 1 memory operand, 2 push/pop, 3 string destination, 4 I/O |
| req_base | input | 2 | Base register in use for kind 1 |
| req_offset | input | 16 | Offset or I/O port number |
| req_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| bus_valid | output | 1 | A bus cycle address is present |
| bus_addr | output | 20 | Physical byte address |
| bus_be | output | 2 | Byte-lane enables (bit 0 even lane, bit 1 odd lane) |
| bus_io | output | 1 | Cycle targets the I/O space |
| bus_split | output | 1 | Cycle belongs to a two-cycle odd word |
| bus_phase | output | 1 | 0 first cycle, 1 second cycle of a split |

## Verification
A request placed on the inputs ahead of a rising edge is accepted on that edge. Its first bus cycle is registered on the same edge, so the bench reads it at the following falling edge. The second half of a split word appears one edge later and is read at the next falling edge, where req_ready is also checked low. A segment write or a lone prefix registers on one edge and becomes visible to a request accepted on any later edge. The bench therefore keeps every write and every request to its own cycle, except in the same-cycle write case it targets on purpose.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

    typedef enum logic [2:0] {
        KIND_FETCH  = 3'd0,
        KIND_MEM    = 3'd1,
        KIND_STACK  = 3'd2,
        KIND_STRDST = 3'd3,
        KIND_IO     = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BX   = 2'd1,
        BASE_BP   = 2'd2,
        BASE_SP   = 2'd3
    } base_sel_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef struct packed {
        seg_id_e seg;
        logic    flat;
        logic    consume;
    } seg_pick_t;

    // Segment chosen when no override applies.
    function automatic seg_id_e default_seg(acc_kind_e kind, base_sel_e base);
        seg_id_e s;
        case (kind)
            KIND_MEM:    s = (base == BASE_BP || base == BASE_SP) ? SEG_STACK : SEG_DATA;
            KIND_STACK:  s = SEG_STACK;
            KIND_STRDST: s = SEG_EXTRA;
            default:     s = SEG_CODE;
        endcase
        return s;
    endfunction

    // Byte-lane enables for a first bus cycle.
    function automatic logic [1:0] first_lanes(logic word, logic odd);
        logic [1:0] be;
        if (word && !odd)  be = 2'b11;
        else if (odd)      be = 2'b10;
        else               be = 2'b01;
        return be;
    endfunction

endpackage

// File: rtl/segaddr_regs.sv
module segaddr_regs #(
    parameter int SEG_W  = 16,
    parameter int N_SEG  = 4,
    localparam int SEL_W = $clog2(N_SEG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [SEG_W-1:0]             wr_data,
    output logic [N_SEG-1:0][SEG_W-1:0]  seg_q
);
    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                seg_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/segaddr_sel.sv
module segaddr_sel
    import segaddr_pkg::*;
(
    input  acc_kind_e kind,
    input  base_sel_e base,
    input  logic      ovr_active,
    input  seg_id_e   ovr_seg,
    output seg_pick_t pick
);
    always_comb begin
        pick.flat    = (kind == KIND_IO);
        pick.consume = (kind == KIND_MEM);
        if (kind == KIND_MEM && ovr_active)
            pick.seg = ovr_seg;
        else
            pick.seg = default_seg(kind, base);
    end
endmodule

// File: rtl/segaddr_calc.sv
module segaddr_calc #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0] seg_base,
    input  logic [OFS_W-1:0] offset,
    input  logic             flat,
    input  logic             second,
    output logic [PA_W-1:0]  phys
);
    logic [OFS_W-1:0] ofs_eff;
    logic [PA_W-1:0]  seg_ext;

    always_comb begin
        ofs_eff = offset + OFS_W'(second);
        seg_ext = {seg_base, {SEG_SHIFT{1'b0}}};
        if (flat)
            phys = PA_W'(ofs_eff);
        else
            phys = seg_ext + PA_W'(ofs_eff);
    end
endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
    import segaddr_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT,
    localparam int N_SEG    = 4,
    localparam int SEL_W    = $clog2(N_SEG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seg_wr_en,
    input  logic [SEL_W-1:0] seg_wr_sel,
    input  logic [OFS_W-1:0] seg_wr_data,
    input  logic             pfx_valid,
    input  logic [SEL_W-1:0] pfx_seg,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_kind,
    input  logic [1:0]       req_base,
    input  logic [OFS_W-1:0] req_offset,
    input  logic             req_word,
    output logic             bus_valid,
    output logic [PA_W-1:0]  bus_addr,
    output logic [1:0]       bus_be,
    output logic             bus_io,
    output logic             bus_split,
    output logic             bus_phase
);
    logic [N_SEG-1:0][OFS_W-1:0] seg_q;
    logic                        pend_q;
    seg_id_e                     pend_seg_q;
    logic                        ovr_active;
    seg_id_e                     ovr_seg;
    seg_pick_t                   pick;
    logic [1:0][PA_W-1:0]        phys_w;
    logic [PA_W-1:0]             next_addr_q;
    logic                        accept;
    logic                        odd_word;

    segaddr_regs #(.SEG_W(OFS_W), .N_SEG(N_SEG)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_q)
    );

    always_comb begin
        ovr_active = pfx_valid || pend_q;
        ovr_seg    = pfx_valid ? seg_id_e'(pfx_seg) : pend_seg_q;
    end

    segaddr_sel sel_i (
        .kind       (acc_kind_e'(req_kind)),
        .base       (base_sel_e'(req_base)),
        .ovr_active (ovr_active),
        .ovr_seg    (ovr_seg),
        .pick       (pick)
    );

    for (genvar g = 0; g < 2; g++) begin : g_byte
        segaddr_calc #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) calc_i (
            .seg_base (seg_q[pick.seg]),
            .offset   (req_offset),
            .flat     (pick.flat),
            .second   (1'(g)),
            .phys     (phys_w[g])
        );
    end

    assign req_ready = !(bus_valid && bus_split && !bus_phase);
    assign accept    = req_valid && req_ready;
    assign odd_word  = req_word && req_offset[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_seg_q <= SEG_CODE;
        end else if (accept && pick.consume) begin
            pend_q     <= 1'b0;
        end else if (pfx_valid) begin
            pend_q     <= 1'b1;
            pend_seg_q <= seg_id_e'(pfx_seg);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid   <= 1'b0;
            bus_addr    <= '0;
            bus_be      <= 2'b00;
            bus_io      <= 1'b0;
            bus_split   <= 1'b0;
            bus_phase   <= 1'b0;
            next_addr_q <= '0;
        end else if (accept) begin
            bus_valid   <= 1'b1;
            bus_addr    <= phys_w[0];
            bus_be      <= first_lanes(req_word, req_offset[0]);
            bus_io      <= pick.flat;
            bus_split   <= odd_word;
            bus_phase   <= 1'b0;
            next_addr_q <= phys_w[1];
        end else if (!req_ready) begin
            bus_addr    <= next_addr_q;
            bus_be      <= 2'b01;
            bus_phase   <= 1'b1;
        end else begin
            bus_valid   <= 1'b0;
            bus_be      <= 2'b00;
            bus_split   <= 1'b0;
            bus_phase   <= 1'b0;
        end
    end
endmodule

// File: rtl/segaddr_chk.sv
module segaddr_chk #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            bus_valid,
    input logic [PA_W-1:0] bus_addr,
    input logic [1:0]      bus_be,
    input logic            bus_io,
    input logic            bus_split,
    input logic            bus_phase
);
    // R1
    accept_show_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> bus_valid && !bus_phase);

    // R9
    split_follow_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_split && !bus_phase |=> bus_valid && bus_split && bus_phase);

    // R9
    split_stall_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_split && !bus_phase |-> !req_ready);

    // R9
    split_lane_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_split |-> $countones(bus_be) == 1 && (bus_addr[0] != bus_phase));

    // R7
    io_upper_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_io |-> bus_addr[PA_W-1:OFS_W] == '0);

    // R8
    word_even_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_split && bus_be == 2'b11 |-> !bus_addr[0]);

    // R8
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_split && $countones(bus_be) == 1 |-> bus_be[1] == bus_addr[0]);

    // R12
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> req_ready);
endmodule

bind segaddr_gen segaddr_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_io    (bus_io),
    .bus_split (bus_split),
    .bus_phase (bus_phase)
);

// File: tb/segaddr_gen_tb_top.sv
module segaddr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        pfx_valid;
    logic [1:0]  pfx_seg;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_kind;
    logic [1:0]  req_base;
    logic [15:0] req_offset;
    logic        req_word;
    logic        bus_valid;
    logic [19:0] bus_addr;
    logic [1:0]  bus_be;
    logic        bus_io;
    logic        bus_split;
    logic        bus_phase;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] m_seg [4];
    bit          m_pv;
    logic [1:0]  m_ps;

    always #2 clk = ~clk;

    segaddr_gen dut_i (
        .clk(clk), .rst(rst),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .pfx_valid(pfx_valid), .pfx_seg(pfx_seg),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_base(req_base), .req_offset(req_offset), .req_word(req_word),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_io(bus_io), .bus_split(bus_split), .bus_phase(bus_phase)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(logic [15:0] seg, logic [15:0] ofs, bit io);
        logic [19:0] a;
        if (io) a = {4'h0, ofs};
        else    a = {seg, 4'h0} + {4'h0, ofs};
        return a;
    endfunction

    function automatic logic [1:0] pick_seg(logic [2:0] kind, logic [1:0] base, bit ov, logic [1:0] os);
        logic [1:0] s;
        case (kind)
            3'd1: s = ov ? os : ((base >= 2'd2) ? 2'd2 : 2'd1);
            3'd2: s = 2'd2;
            3'd3: s = 2'd3;
            default: s = 2'd0;
        endcase
        return s;
    endfunction

    task automatic seg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(posedge clk); #1;
        seg_wr_en = 1'b0;
        m_seg[sel] = val;
    endtask

    task automatic prefix_only(input logic [1:0] s);
        @(negedge clk);
        pfx_valid = 1'b1; pfx_seg = s;
        @(posedge clk); #1;
        pfx_valid = 1'b0;
        m_pv = 1; m_ps = s;
    endtask

    task automatic do_req(input logic [2:0] kind, input logic [1:0] base, input logic [15:0] ofs,
                          input bit word, input bit pv, input logic [1:0] ps, input string tag,
                          input bit wr = 0, input logic [1:0] wsel = 0, input logic [15:0] wval = 0);
        bit ov; logic [1:0] os; logic [1:0] sg; bit io; bit split;
        logic [19:0] a0, a1; logic [1:0] be0;
        @(negedge clk);
        chk(bus_valid == 1'b0 && req_ready == 1'b1, {tag, " idle before request"},
            {bus_valid, req_ready}, 2'b01);
        ov = pv || m_pv;
        os = pv ? ps : m_ps;
        sg = pick_seg(kind, base, ov, os);
        io = (kind == 3'd4);
        split = word && ofs[0];
        a0 = phys(m_seg[sg], ofs, io);
        a1 = phys(m_seg[sg], ofs + 16'd1, io);
        be0 = (word && !ofs[0]) ? 2'b11 : (ofs[0] ? 2'b10 : 2'b01);
        if (kind == 3'd1) m_pv = 0;
        else if (pv) begin m_pv = 1; m_ps = ps; end
        req_valid = 1'b1; req_kind = kind; req_base = base; req_offset = ofs; req_word = word;
        pfx_valid = pv; pfx_seg = ps;
        seg_wr_en = wr; seg_wr_sel = wsel; seg_wr_data = wval;
        @(posedge clk); #1;
        req_valid = 1'b0; pfx_valid = 1'b0; seg_wr_en = 1'b0;
        if (wr) m_seg[wsel] = wval;
        @(negedge clk);
        chk(bus_valid && bus_addr == a0, {tag, " first address"}, bus_addr, a0);
        chk(bus_be == be0 && bus_io == io && bus_split == split && !bus_phase,
            {tag, " first lanes/flags"}, {bus_be, bus_io, bus_split, bus_phase},
            {be0, io, split, 1'b0});
        if (split) begin
            chk(req_ready == 1'b0, {tag, " R9 ready held low"}, req_ready, 0);
            @(negedge clk);
            chk(bus_valid && bus_addr == a1, {tag, " R9 second address"}, bus_addr, a1);
            chk(bus_be == 2'b01 && bus_split && bus_phase, {tag, " R9 second lanes"},
                {bus_be, bus_split, bus_phase}, 4'b0111);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
        m_pv = 0; m_ps = 0;
        rst = 1'b1; seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
        pfx_valid = 0; pfx_seg = 0; req_valid = 0; req_kind = 0; req_base = 0;
        req_offset = 0; req_word = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(bus_valid == 0 && req_ready == 1, "R12 reset outputs", {bus_valid, req_ready}, 2'b01);
        do_req(3'd1, 2'd0, 16'h1234, 0, 0, 0, "R12 zero segments");
        do_req(3'd1, 2'd2, 16'h0042, 0, 0, 0, "R12 no pending override");

        // R11 segment loads
        seg_write(2'd0, 16'h1000);
        seg_write(2'd1, 16'h2000);
        seg_write(2'd2, 16'h3000);
        seg_write(2'd3, 16'h4000);
        // R1 R2 fetch from code segment
        do_req(3'd0, 2'd0, 16'h0010, 0, 0, 0, "R1 R2 fetch");
        // R3 base register defaults
        do_req(3'd1, 2'd0, 16'h0100, 1, 0, 0, "R3 index-only data");
        do_req(3'd1, 2'd1, 16'h0102, 1, 0, 0, "R3 BX data");
        do_req(3'd1, 2'd2, 16'h0104, 1, 0, 0, "R3 BP stack");
        do_req(3'd1, 2'd3, 16'h0106, 1, 0, 0, "R3 SP stack");
        // R4 push/pop ignores override
        do_req(3'd2, 2'd0, 16'hFFFE, 1, 1, 2'd3, "R4 push with prefix");
        do_req(3'd1, 2'd2, 16'h0008, 0, 0, 0, "R4 prefix left pending used");
        // R5 string destination
        do_req(3'd3, 2'd0, 16'h0020, 0, 1, 2'd0, "R5 string dest with prefix");
        do_req(3'd1, 2'd0, 16'h0021, 0, 0, 0, "R5 pending prefix survives");
        // R2 fetch leaves override pending
        prefix_only(2'd2);
        do_req(3'd0, 2'd0, 16'h0030, 0, 0, 0, "R2 fetch ignores prefix");
        do_req(3'd1, 2'd1, 16'h0032, 0, 0, 0, "R6 pending override applied");
        do_req(3'd1, 2'd1, 16'h0034, 0, 0, 0, "R6 override consumed");
        do_req(3'd1, 2'd2, 16'h0036, 1, 1, 2'd3, "R6 same-cycle override");
        // R7 I/O
        do_req(3'd4, 2'd0, 16'h03F8, 0, 0, 0, "R7 io byte");
        do_req(3'd4, 2'd0, 16'hFFFF, 1, 0, 0, "R7 R9 io odd word wrap");
        // R8 lanes
        do_req(3'd1, 2'd0, 16'h0200, 0, 0, 0, "R8 even byte");
        do_req(3'd1, 2'd0, 16'h0201, 0, 0, 0, "R8 odd byte");
        do_req(3'd1, 2'd0, 16'h0202, 1, 0, 0, "R8 even word");
        // R9 odd word with in-segment wrap
        do_req(3'd1, 2'd0, 16'hFFFF, 1, 0, 0, "R9 odd word offset wrap");
        do_req(3'd1, 2'd1, 16'h1235, 1, 0, 0, "R9 odd word");
        // R10 20-bit wrap
        seg_write(2'd1, 16'hFFFF);
        do_req(3'd1, 2'd0, 16'h0020, 0, 0, 0, "R10 physical wrap");
        // R11 same-cycle write uses old base
        do_req(3'd1, 2'd0, 16'h0040, 0, 0, 0, "R11 write same cycle", 1, 2'd1, 16'h5000);
        do_req(3'd1, 2'd0, 16'h0040, 0, 0, 0, "R11 new base after write");

        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 10;
            if (r == 0) seg_write(2'($urandom), 16'($urandom));
            else if (r == 1) prefix_only(2'($urandom));
            else do_req(3'($urandom % 5), 2'($urandom), 16'($urandom), 1'($urandom),
                        ($urandom % 4) == 0, 2'($urandom), "R1 R9 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule